// File: doc/BRIEF.md
# Tiled Background Pixel Pipeline

This block draws one background layer made of 8x8 tiles on a 16x16 grid, which covers the 128x128 visible part of a 256x256 raster. It runs on the pixel clock and takes the current raster position (`hcount`, `vcount`) as input. During each 8-pixel span it looks up one grid entry and the matching tile row in an external byte-wide video memory. That row is then shifted out during the following span, one colour index per tick. Each colour index is combined with the entry's palette number to read a 64-byte internal colour table. The table byte is expanded to 9-bit RGB.

Tiles hold either 1 or 2 bits per pixel, chosen by `two_bit`. The grid and tile areas start at the addresses given on `grid_base` and `tile_base`. The colour table is loaded through a simple write port. Output pixels lag the raster by a fixed ten ticks. Any pixel that falls outside the visible area comes out black.

Top module: `bg_tile_pipe`

## Requirements
- R1: At span phase 0 (`hcount[2:0]`=0) `vram_addr` = `grid_base` + 2*(`hcount[6:3]` + 16*`vcount[6:3]`). At phase 1 it is that address + 1. All addresses wrap modulo 8192.
- R2: The byte read from the lower grid address is the 8-bit tile number. Bits [3:0] of the byte at the upper address are the palette number, and bits [7:4] of that byte have no effect on any pixel.
- R3: With `two_bit`=0, the phase-2 address is `tile_base` + tile*8 + (`vcount` mod 8). A pixel's colour index is one bit of that byte, and the colour table entry read is palette*2 + index.
- R4: With `two_bit`=1, the phase-2 address is `tile_base` + tile*16 + (`vcount` mod 8)*2 and supplies the index's low bit. The phase-3 address is one higher and supplies the high bit. The colour table entry read is palette*4 + index.
- R5: Exactly one memory address is issued per pixel tick, and all reads for one tile finish by phase 3 of its span. Read data is used one tick after its address.
- R6: Pixels leave in left-to-right order, and bit 7 of a row byte is the leftmost pixel. The pixel at (x, y) appears on the RGB outputs in the tick where `hcount` = x+10 and `vcount` = y.
- R7: A colour table byte c is output as red = c[2:0], green = c[5:3], blue = {c[7:6], 0}.
- R8: A pixel whose x or y is 128 or more (bit 7 set) is output as all-zero RGB.
- R9: When `cram_we` is high at a clock edge, `cram_wdata` is stored at `cram_waddr` (0..63), and later pixels that use that entry show the new value.
- R10: Synchronous active-high `rst` forces the RGB outputs to zero. They stay zero until new pixels have passed through the whole pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hcount | input | 8 | Raster column of the current tick |
| vcount | input | 8 | Raster line of the current tick |
| grid_base | input | 13 | Start address of the grid area |
| tile_base | input | 13 | Start address of the tile area |
| two_bit | input | 1 | 1 = 2 bits per pixel, 0 = 1 bit per pixel |
| vram_addr | output | 13 | Video memory read address |
| vram_rdata | input | 8 | Read data, valid one tick after its address |
| cram_we | input | 1 | Colour table write enable |
| cram_waddr | input | 6 | Colour table write address |
| cram_wdata | input | 8 | Colour table write data |
| red | output | 3 | Red component |
| green | output | 3 | Green component |
| blue | output | 3 | Blue component, LSB always zero |

## Verification
Some properties are checked by assertions on every cycle:
- the two grid reads land on consecutive addresses;
- the two plane reads in 2-bit mode land on consecutive addresses;
- a 1-bit row address stays inside a 2 KB window above the tile base;
- the palette only changes on a span boundary;
- no coloured pixel comes from a blanked raster position;
- reset clears the output.

Other behaviour depends on memory contents, so only the bench scenarios can show it:
- that the right tile and row are chosen;
- that the index bits are ordered correctly and pixels come out in the right order;
- that the high palette nibble is ignored;
- the exact ten-tick delay;
- the colour unpacking;
- the effect of rewriting the colour table.

// File: rtl/bgtile_pkg.sv
package bgtile_pkg;

    localparam int unsigned VA_W      = 13;            // video memory address width
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned RC_W      = 8;             // raster counter width
    localparam int unsigned TILE_LOG  = 3;             // 8-pixel tiles
    localparam int unsigned GRID_LOG  = 4;             // 16 tiles per grid side
    localparam int unsigned PAL_W     = 4;             // 16 palettes
    localparam int unsigned CIDX_W    = 2;             // up to 4 colours
    localparam int unsigned CA_W      = PAL_W + CIDX_W;
    localparam int unsigned CRAM_N    = 1 << CA_W;
    localparam int unsigned TILE_PX   = 1 << TILE_LOG;
    localparam int unsigned VIS_STAGES = TILE_PX + 1;  // span delay + colour read

    typedef logic [VA_W-1:0]   vaddr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [TILE_LOG-1:0] {
        PH_GRID_LO = 3'd0,
        PH_GRID_HI = 3'd1,
        PH_ROW_LO  = 3'd2,
        PH_ROW_HI  = 3'd3,
        PH_TAIL    = 3'd4,
        PH_IDLE5   = 3'd5,
        PH_IDLE6   = 3'd6,
        PH_LOAD    = 3'd7
    } phase_e;

    typedef struct packed {
        byte_t            plane_lo;
        byte_t            plane_hi;
        logic [PAL_W-1:0] pal;
    } tile_row_t;

    typedef struct packed {
        logic [2:0] r;
        logic [2:0] g;
        logic [2:0] b;
    } rgb9_t;

    function automatic vaddr_t grid_addr(vaddr_t base, logic [GRID_LOG-1:0] tx,
                                         logic [GRID_LOG-1:0] ty);
        return base + vaddr_t'({ty, tx, 1'b0});
    endfunction

    function automatic vaddr_t row_addr(vaddr_t base, byte_t tile,
                                        logic [TILE_LOG-1:0] row, logic two_bit);
        if (two_bit)
            return base + vaddr_t'({tile, row, 1'b0});
        return base + vaddr_t'({tile, row});
    endfunction

    function automatic rgb9_t decode_colour(byte_t c);
        rgb9_t o;
        o.r = c[2:0];
        o.g = c[5:3];
        o.b = {c[7:6], 1'b0};
        return o;
    endfunction

endpackage

// File: rtl/bgt_fetch.sv
module bgt_fetch
    import bgtile_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RC_W-1:0] hcount,
    input  logic [RC_W-1:0] vcount,
    input  vaddr_t          grid_base,
    input  vaddr_t          tile_base,
    input  logic            two_bit,
    output vaddr_t          vram_addr,
    input  byte_t           vram_rdata,
    output logic            load,
    output tile_row_t       row_out
);

    phase_e              phase;
    vaddr_t              gaddr_q;
    logic [TILE_LOG-1:0] row_q;
    byte_t               tile_q;
    tile_row_t           acc_q;
    vaddr_t              plane_addr;

    assign phase      = phase_e'(hcount[TILE_LOG-1:0]);
    assign plane_addr = row_addr(tile_base, tile_q, row_q, two_bit);

    always_comb begin
        unique case (phase)
            PH_GRID_LO: vram_addr = grid_addr(grid_base,
                                      hcount[TILE_LOG+GRID_LOG-1:TILE_LOG],
                                      vcount[TILE_LOG+GRID_LOG-1:TILE_LOG]);
            PH_GRID_HI: vram_addr = gaddr_q + vaddr_t'(1);
            PH_ROW_LO:  vram_addr = plane_addr;
            default:    vram_addr = plane_addr + vaddr_t'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gaddr_q <= '0;
            row_q   <= '0;
            tile_q  <= '0;
            acc_q   <= '0;
        end else begin
            unique case (phase)
                PH_GRID_LO: begin
                    gaddr_q <= vram_addr;
                    row_q   <= vcount[TILE_LOG-1:0];
                end
                PH_GRID_HI: tile_q         <= vram_rdata;
                PH_ROW_LO:  acc_q.pal      <= vram_rdata[PAL_W-1:0];
                PH_ROW_HI:  acc_q.plane_lo <= vram_rdata;
                PH_TAIL:    acc_q.plane_hi <= two_bit ? vram_rdata : '0;
                default:    ;
            endcase
        end
    end

    assign load    = (phase == PH_LOAD);
    assign row_out = acc_q;

    // R1: second grid byte sits right after the first
    p_grid_pair_r1: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_GRID_HI && $past(phase) == PH_GRID_LO)
            |-> vram_addr == $past(vram_addr) + vaddr_t'(1));

    // R4: the two plane bytes of a row are adjacent
    p_plane_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (two_bit && $past(two_bit) && phase == PH_ROW_HI && $past(phase) == PH_ROW_LO)
            |-> vram_addr == $past(vram_addr) + vaddr_t'(1));

    // R3: a 1-bit row lies within 256 tiles * 8 bytes of the tile base
    p_row_window_r3: assert property (@(posedge clk) disable iff (rst)
        (!two_bit && phase == PH_ROW_LO)
            |-> vaddr_t'(vram_addr - tile_base) < vaddr_t'(2048));

endmodule

// File: rtl/bgt_shift.sv
module bgt_shift
    import bgtile_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  tile_row_t        row_in,
    output logic [CIDX_W-1:0] cidx,
    output logic [PAL_W-1:0] pal
);

    tile_row_t cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= row_in;
        end else begin
            cur_q.plane_lo <= {cur_q.plane_lo[BYTE_W-2:0], 1'b0};
            cur_q.plane_hi <= {cur_q.plane_hi[BYTE_W-2:0], 1'b0};
        end
    end

    assign cidx = {cur_q.plane_hi[BYTE_W-1], cur_q.plane_lo[BYTE_W-1]};
    assign pal  = cur_q.pal;

    // R2: palette only changes when a new row is loaded
    p_pal_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> $stable(pal));

endmodule

// File: rtl/bgt_cram.sv
module bgt_cram
    import bgtile_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [CA_W-1:0] waddr,
    input  byte_t           wdata,
    input  logic [CA_W-1:0] raddr,
    output byte_t           rdata
);

    byte_t mem [CRAM_N];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= mem[raddr];
    end

endmodule

// File: rtl/bg_tile_pipe.sv
module bg_tile_pipe
    import bgtile_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RC_W-1:0]   hcount,
    input  logic [RC_W-1:0]   vcount,
    input  logic [VA_W-1:0]   grid_base,
    input  logic [VA_W-1:0]   tile_base,
    input  logic              two_bit,
    output logic [VA_W-1:0]   vram_addr,
    input  logic [BYTE_W-1:0] vram_rdata,
    input  logic              cram_we,
    input  logic [CA_W-1:0]   cram_waddr,
    input  logic [BYTE_W-1:0] cram_wdata,
    output logic [2:0]        red,
    output logic [2:0]        green,
    output logic [2:0]        blue
);

    logic                  load;
    tile_row_t             fetched;
    logic [CIDX_W-1:0]     cidx;
    logic [PAL_W-1:0]      pal;
    logic [CA_W-1:0]       cram_raddr;
    byte_t                 colour;
    logic [VIS_STAGES-1:0] vis_q;
    rgb9_t                 rgb_q;

    bgt_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .hcount     (hcount),
        .vcount     (vcount),
        .grid_base  (grid_base),
        .tile_base  (tile_base),
        .two_bit    (two_bit),
        .vram_addr  (vram_addr),
        .vram_rdata (vram_rdata),
        .load       (load),
        .row_out    (fetched)
    );

    bgt_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .row_in (fetched),
        .cidx   (cidx),
        .pal    (pal)
    );

    assign cram_raddr = two_bit ? {pal, cidx} : {1'b0, pal, cidx[0]};

    bgt_cram u_cram (
        .clk   (clk),
        .rst   (rst),
        .we    (cram_we),
        .waddr (cram_waddr),
        .wdata (cram_wdata),
        .raddr (cram_raddr),
        .rdata (colour)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vis_q <= '0;
            rgb_q <= '0;
        end else begin
            vis_q <= {vis_q[VIS_STAGES-2:0], ~hcount[RC_W-1] & ~vcount[RC_W-1]};
            rgb_q <= vis_q[VIS_STAGES-1] ? decode_colour(colour) : '0;
        end
    end

    assign red   = rgb_q.r;
    assign green = rgb_q.g;
    assign blue  = rgb_q.b;

    // R10: reset clears the pixel output on the next edge
    p_reset_black_r10: assert property (@(posedge clk)
        rst |=> ({red, green, blue} == 9'd0));

    // R8: a coloured pixel must come from a visible raster position ten ticks back
    p_blank_black_r8: assert property (@(posedge clk) disable iff (rst)
        ({red, green, blue} != 9'd0) |-> $past(!hcount[RC_W-1] && !vcount[RC_W-1], 10));

endmodule

// File: tb/bg_tile_pipe_test.sv
module bg_tile_pipe_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  hcount = 8'd200;
    logic [7:0]  vcount = 8'd200;
    logic [12:0] grid_base = '0;
    logic [12:0] tile_base = '0;
    logic        two_bit = 1'b0;
    logic [12:0] vram_addr;
    logic [7:0]  vram_rdata;
    logic        cram_we = 1'b0;
    logic [5:0]  cram_waddr = '0;
    logic [7:0]  cram_wdata = '0;
    logic [2:0]  red, green, blue;

    int    checks = 0;
    int    fails  = 0;
    int    since  = 0;
    bit    prev_rst = 1'b1;
    bit    done = 1'b0;
    string extra = "";
    logic [7:0] cmem [64];

    always #5 clk = ~clk;

    bg_tile_pipe uut (
        .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
        .grid_base(grid_base), .tile_base(tile_base), .two_bit(two_bit),
        .vram_addr(vram_addr), .vram_rdata(vram_rdata),
        .cram_we(cram_we), .cram_waddr(cram_waddr), .cram_wdata(cram_wdata),
        .red(red), .green(green), .blue(blue)
    );

    function automatic logic [7:0] vb(int a);
        int m;
        m = a & 8191;
        return 8'(((m * 37) ^ ((m >> 3) * 11) ^ 90) & 255);
    endfunction

    // synchronous read memory model, one tick of latency
    always_ff @(posedge clk) vram_rdata <= vb(int'(vram_addr));

    // mode, grid base, tile base
    localparam logic [26:0] CFG [4] = '{
        {1'b0, 13'h0000, 13'h0800},
        {1'b1, 13'h0000, 13'h0800},
        {1'b1, 13'h1F00, 13'h1A00},
        {1'b0, 13'h0123, 13'h1FF0}
    };
    localparam int LINES [10] = '{0, 7, 8, 15, 63, 64, 120, 127, 128, 200};

    function automatic logic [8:0] ref_px(int x, int y);
        int e, tile, pal, row, bi, ci, ca, tb;
        logic [7:0] b0, b1, col;
        tb   = int'(tile_base);
        e    = int'(grid_base) + 2 * ((y >> 3) * 16 + (x >> 3));
        tile = int'(vb(e));
        pal  = int'(vb(e + 1)) & 15;     // upper nibble dropped (R2)
        row  = y & 7;
        bi   = 7 - (x & 7);              // MSB is leftmost (R6)
        if (two_bit) begin
            b0 = vb(tb + tile * 16 + row * 2);
            b1 = vb(tb + tile * 16 + row * 2 + 1);
            ci = int'(b1[bi]) * 2 + int'(b0[bi]);
            ca = pal * 4 + ci;
        end else begin
            b0 = vb(tb + tile * 8 + row);
            ci = int'(b0[bi]);
            ca = pal * 2 + ci;
        end
        col = cmem[ca];
        return {col[2:0], col[5:3], col[7:6], 1'b0};
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step(input int h, input int v);
        int ph, ga, ra, tile;
        int got, exp;
        @(negedge clk);
        hcount = 8'(h);
        vcount = 8'(v);
        #1;
        got = int'({red, green, blue});
        if (rst) begin
            since = 0;
            if (prev_rst) chk("R10 held in reset", got, 0);
            prev_rst = 1'b1;
            return;
        end
        prev_rst = 1'b0;
        since++;
        if (since <= 9) begin
            chk("R10 after reset", got, 0);
        end else if (since >= 24) begin
            if (h >= 10 && h <= 137 && v < 128) begin
                exp = int'(ref_px(h - 10, v));
                chk($sformatf("%s R6 R7 R2 %s px(%0d,%0d)", two_bit ? "R4" : "R3",
                              extra, h - 10, v), got, exp);
            end else begin
                chk($sformatf("R8 blank h=%0d v=%0d", h, v), got, 0);
            end
        end
        if (since >= 9) begin
            ph = h & 7;
            ga = (int'(grid_base) + 2 * (((v >> 3) & 15) * 16 + ((h >> 3) & 15))) & 8191;
            tile = int'(vb(ga));
            ra = two_bit ? int'(tile_base) + tile * 16 + (v & 7) * 2
                         : int'(tile_base) + tile * 8 + (v & 7);
            ra = ra & 8191;
            if (ph == 0) chk("R1 grid lo addr", int'(vram_addr), ga);
            if (ph == 1) chk("R1 R5 grid hi addr", int'(vram_addr), (ga + 1) & 8191);
            if (ph == 2) chk(two_bit ? "R2 R4 plane lo addr" : "R2 R3 row addr",
                             int'(vram_addr), ra);
            if (ph == 3 && two_bit) chk("R4 R5 plane hi addr", int'(vram_addr), (ra + 1) & 8191);
        end
    endtask

    task automatic run_line(input int v);
        for (int h = 0; h < 256; h++) step(h, v);
    endtask

    task automatic write_cram(input int seed_mul, input int seed_add);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            cram_we    = 1'b1;
            cram_waddr = 6'(i);
            cram_wdata = 8'((i * seed_mul + seed_add) & 255);
            cmem[i]    = cram_wdata;
        end
        @(negedge clk);
        cram_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL all-reqs watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // reset state
        for (int i = 0; i < 4; i++) step(200, 200);
        write_cram(73, 19);
        rst = 1'b0;

        // table-driven configurations
        for (int c = 0; c < 4; c++) begin
            two_bit   = CFG[c][26];
            grid_base = CFG[c][25:13];
            tile_base = CFG[c][12:0];
            for (int l = 0; l < 10; l++) run_line(LINES[l]);
        end

        // R9: rewrite the colour table, then redraw
        write_cram(29, 3);
        two_bit   = 1'b1;
        grid_base = 13'h0040;
        tile_base = 13'h0400;
        extra     = "R9";
        run_line(200);
        run_line(8);
        run_line(9);
        extra     = "";

        // R10: reset in the middle of a visible line
        for (int h = 0; h < 50; h++) step(h, 30);
        rst = 1'b1;
        step(50, 30);
        step(51, 30);
        rst = 1'b0;
        for (int h = 52; h < 256; h++) step(h, 30);
        run_line(31);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule